// File: doc/BRIEF.md
# Switching Frame Clock Selector with Shared Sync

This block produces the switching frame clock for a two-channel class-D output stage. A 3-bit rate select input picks one of five frame rates. In master role the block divides the system clock by an integer to make the frame, and drives that frame clock onto a shared sync line so that other output stages can follow it. In slave role it leaves the sync line undriven and takes its frame from the incoming sync clock. A watchdog flags a missing sync clock.

Role and gain step come from a 3-bit code that an external converter supplies. The block captures that code once, when the start-up interval ends after the run enable is raised. The captured value then stays fixed until the next reset. Until that capture the block stays quiet.

Top module: `swclk_sync_sel`

## Requirements
- R1: In master role the interval between `frame_start` pulses is SYS_CLK_HZ/rate clock cycles, rounded down. The rate for each `rate_sel` code is: 0 = 400 kHz, 1 = 500 kHz, 2 = 600 kHz, 3 = 1000 kHz, 4 = 1200 kHz. `frame_clk` is high for the first floor(period/2) cycles of each frame, beginning with the cycle in which `frame_start` is high.
- R2: The `rate_sel` codes 5, 6 and 7 are reserved. One cycle after a reserved code is applied, `cfg_err` goes high. While the code is reserved, the frame period keeps its last valid value. `cfg_err` returns low one cycle after a valid code is applied.
- R3: A new `rate_sel` value takes effect only at a frame boundary. The frame in progress completes with its old period, so no shortened frame occurs.
- R4: `cfg_valid` rises on the STARTUP_CYCLES-th rising clock edge of an unbroken stretch with `run_en` high. If `run_en` goes low before that edge, the count starts again from zero. While `cfg_valid` is low, `frame_clk`, `frame_start` and `sync_oe` are all 0. While `run_en` is low, `frame_clk` is also 0.
- R5: `cfg_code` is decoded as follows. Bit 2 selects the role: 0 = master, 1 = slave, shown on `slave_mode`. Bits 1:0 select the gain step, shown on `gain_db` in dB: 0 = 20, 1 = 26, 2 = 32, 3 = 36.
- R6: After `cfg_valid` rises, `gain_db`, `slave_mode` and `cfg_valid` do not change until `rst_n` is asserted. Later changes on `cfg_code` and cycling `run_en` are ignored.
- R7: In master role `sync_oe` is 1 whenever frames run, and `sync_out` equals `frame_clk`. `sync_lost` stays 0 in master role.
- R8: In slave role `sync_oe` stays 0. `frame_start` is high in the cycle that follows the second rising clock edge after `sync_in` rises. The interval between `frame_start` pulses equals the period of the sync clock, and `frame_clk` follows `sync_in` with the same delay.
- R9: In slave role `sync_lost` rises once no sync rising edge has been seen for 4 frame periods of the selected rate. It clears after the next sync rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; re-arms the configuration capture |
| run_en | input | 1 | Run enable; high releases start-up and frame generation |
| rate_sel | input | 3 | Frame rate select code |
| cfg_code | input | 3 | Role and gain code from the external converter |
| sync_in | input | 1 | Sync clock from the shared line (used in slave role) |
| sync_out | output | 1 | Frame clock driven onto the shared line |
| sync_oe | output | 1 | Drive enable for the shared sync line |
| frame_clk | output | 1 | Frame clock for the output stage |
| frame_start | output | 1 | One-cycle pulse at each frame boundary |
| cfg_valid | output | 1 | Configuration has been captured |
| slave_mode | output | 1 | Captured role, 1 = slave |
| gain_db | output | 6 | Captured gain in dB |
| cfg_err | output | 1 | Reserved rate code is applied |
| sync_lost | output | 1 | No sync edge seen within 4 frame periods (slave role) |

## Verification
The master divider is tested with each of the five rate codes in turn, and then with a seeded random sequence of codes. Each measured frame length and high time must match the value from the rate table, which shows that the table and the duty split are both correct. A change of code in the middle of a frame shows whether the update waits for the frame boundary. A reserved code shows whether the last valid period is kept. On the configuration side, a start-up interrupted by a drop of `run_en` shows that the count restarts and does not just resume. Changing `cfg_code` after capture shows the value is frozen. A second reset into slave role exercises the sync path: the edge latency, frame intervals set by an external clock of a period unrelated to the rate table, and a sync clock that stops and then restarts to drive `sync_lost`.

// File: rtl/swclk_pkg.sv
`timescale 1ns/1ps
package swclk_pkg;

  typedef struct packed {
    logic       slave;
    logic [1:0] gain_step;
  } swclk_cfg_t;

  function automatic logic rate_code_ok(input logic [2:0] code);
    return code <= 3'd4;
  endfunction

  // Frame period in system clock cycles for a rate code; 0 for reserved codes.
  function automatic int unsigned frame_period(input logic [2:0] code,
                                               input int unsigned sys_hz);
    case (code)
      3'd0:    return sys_hz / 400_000;
      3'd1:    return sys_hz / 500_000;
      3'd2:    return sys_hz / 600_000;
      3'd3:    return sys_hz / 1_000_000;
      3'd4:    return sys_hz / 1_200_000;
      default: return 0;
    endcase
  endfunction

  function automatic logic [5:0] gain_of(input logic [1:0] step);
    case (step)
      2'd0:    return 6'd20;
      2'd1:    return 6'd26;
      2'd2:    return 6'd32;
      default: return 6'd36;
    endcase
  endfunction

endpackage

// File: rtl/swclk_startup.sv
`timescale 1ns/1ps
module swclk_startup
  import swclk_pkg::*;
#(
  parameter int unsigned STARTUP_CYCLES = 2_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_en,
  input  logic [2:0] cfg_code,
  output logic       cfg_valid,
  output swclk_cfg_t cfg_q
);
  localparam int unsigned SU_W = $clog2(STARTUP_CYCLES + 1);
  localparam logic [SU_W-1:0] SU_LAST = SU_W'(STARTUP_CYCLES - 1);

  logic [SU_W-1:0] su_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      su_cnt    <= '0;
      cfg_valid <= 1'b0;
      cfg_q     <= '0;
    end else if (!cfg_valid) begin
      if (!run_en) begin
        su_cnt <= '0;
      end else if (su_cnt == SU_LAST) begin
        cfg_valid       <= 1'b1;
        cfg_q.slave     <= cfg_code[2];
        cfg_q.gain_step <= cfg_code[1:0];
      end else begin
        su_cnt <= su_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/swclk_rate_reg.sv
`timescale 1ns/1ps
module swclk_rate_reg
  import swclk_pkg::*;
#(
  parameter int unsigned SYS_CLK_HZ = 200_000_000,
  parameter int unsigned PER_W      = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       rate_sel,
  input  logic             boundary,
  output logic [PER_W-1:0] period_q,
  output logic             cfg_err
);
  logic             sel_ok;
  logic [PER_W-1:0] sel_period;

  always_comb begin
    sel_ok     = rate_code_ok(rate_sel);
    sel_period = PER_W'(frame_period(rate_sel, SYS_CLK_HZ));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= PER_W'(frame_period(3'd0, SYS_CLK_HZ));
      cfg_err  <= 1'b0;
    end else begin
      cfg_err <= !sel_ok;
      if (boundary && sel_ok) period_q <= sel_period;
    end
  end

endmodule

// File: rtl/swclk_master_div.sv
`timescale 1ns/1ps
module swclk_master_div #(
  parameter int unsigned PER_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [PER_W-1:0] period,
  output logic             wrap,
  output logic             start,
  output logic             high
);
  logic [PER_W-1:0] cnt;
  logic [PER_W-1:0] half;

  always_comb begin
    half  = period >> 1;
    wrap  = active && (cnt == period - 1'b1);
    start = active && (cnt == '0);
    high  = active && (cnt < half);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!active) cnt <= '0;
    else if (wrap)    cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/swclk_slave_track.sv
`timescale 1ns/1ps
module swclk_slave_track #(
  parameter int unsigned PER_W  = 9,
  parameter int unsigned LOST_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             sync_in,
  input  logic [PER_W-1:0] period,
  output logic             edge_pulse,
  output logic             level,
  output logic             lost
);
  logic              s1, s2, s3;
  logic [LOST_W-1:0] quiet_cnt;
  logic [LOST_W-1:0] limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= sync_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_comb begin
    limit      = {LOST_W'(period), 2'b00} >> 0;
    limit      = LOST_W'(period) << 2;
    edge_pulse = active && s2 && !s3;
    level      = active && s2;
    lost       = active && (quiet_cnt >= limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                quiet_cnt <= '0;
    else if (!active)          quiet_cnt <= '0;
    else if (edge_pulse)       quiet_cnt <= '0;
    else if (quiet_cnt < limit) quiet_cnt <= quiet_cnt + 1'b1;
  end

endmodule

// File: rtl/swclk_sync_sel.sv
`timescale 1ns/1ps
module swclk_sync_sel
  import swclk_pkg::*;
#(
  parameter int unsigned SYS_CLK_HZ     = 200_000_000,
  parameter int unsigned STARTUP_CYCLES = SYS_CLK_HZ / 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_en,
  input  logic [2:0] rate_sel,
  input  logic [2:0] cfg_code,
  input  logic       sync_in,
  output logic       sync_out,
  output logic       sync_oe,
  output logic       frame_clk,
  output logic       frame_start,
  output logic       cfg_valid,
  output logic       slave_mode,
  output logic [5:0] gain_db,
  output logic       cfg_err,
  output logic       sync_lost
);
  localparam int unsigned MAX_PER = SYS_CLK_HZ / 400_000;
  localparam int unsigned PER_W   = $clog2(MAX_PER + 1);
  localparam int unsigned LOST_W  = PER_W + 2;

  swclk_cfg_t       cfg_q;
  logic             active;
  logic             boundary;
  logic [PER_W-1:0] period_q;
  logic             m_wrap, m_start, m_high;
  logic             s_edge, s_level, s_lost;

  swclk_startup #(.STARTUP_CYCLES(STARTUP_CYCLES)) u_startup (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .cfg_code  (cfg_code),
    .cfg_valid (cfg_valid),
    .cfg_q     (cfg_q)
  );

  swclk_rate_reg #(.SYS_CLK_HZ(SYS_CLK_HZ), .PER_W(PER_W)) u_rate (
    .clk      (clk),
    .rst_n    (rst_n),
    .rate_sel (rate_sel),
    .boundary (boundary),
    .period_q (period_q),
    .cfg_err  (cfg_err)
  );

  swclk_master_div #(.PER_W(PER_W)) u_mdiv (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (active && !cfg_q.slave),
    .period (period_q),
    .wrap   (m_wrap),
    .start  (m_start),
    .high   (m_high)
  );

  swclk_slave_track #(.PER_W(PER_W), .LOST_W(LOST_W)) u_strk (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (active && cfg_q.slave),
    .sync_in    (sync_in),
    .period     (period_q),
    .edge_pulse (s_edge),
    .level      (s_level),
    .lost       (s_lost)
  );

  always_comb begin
    active      = cfg_valid && run_en;
    boundary    = !active || (cfg_q.slave ? s_edge : m_wrap);
    slave_mode  = cfg_q.slave;
    gain_db     = gain_of(cfg_q.gain_step);
    frame_clk   = cfg_q.slave ? s_level : m_high;
    frame_start = cfg_q.slave ? s_edge  : m_start;
    sync_oe     = active && !cfg_q.slave;
    sync_out    = sync_oe && m_high;
    sync_lost   = s_lost;
  end

endmodule

// File: rtl/swclk_sync_sel_chk.sv
`timescale 1ns/1ps
module swclk_sync_sel_chk #(
  parameter int unsigned PER_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_valid,
  input logic             slave_mode,
  input logic [5:0]       gain_db,
  input logic             frame_start,
  input logic             frame_clk,
  input logic             sync_oe,
  input logic             sync_out,
  input logic             sync_lost,
  input logic             cfg_err,
  input logic [PER_W-1:0] period_q,
  input logic             boundary
);
  a_r1_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !slave_mode) |=> !frame_start);

  a_r2_reserved_holds: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $stable(period_q));

  a_r3_period_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(period_q) |-> $past(boundary));

  a_r4_quiet_before_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |-> (!frame_clk && !frame_start && !sync_oe));

  a_r6_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_valid) |-> (cfg_valid && $stable(gain_db) && $stable(slave_mode)));

  a_r7_oe_master_only: assert property (@(posedge clk) disable iff (!rst_n)
    sync_oe |-> !slave_mode);

  a_r7_out_follows: assert property (@(posedge clk) disable iff (!rst_n)
    sync_oe |-> (sync_out == frame_clk));

  a_r9_lost_slave_only: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lost |-> slave_mode);

endmodule

bind swclk_sync_sel swclk_sync_sel_chk #(.PER_W(PER_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_valid   (cfg_valid),
  .slave_mode  (slave_mode),
  .gain_db     (gain_db),
  .frame_start (frame_start),
  .frame_clk   (frame_clk),
  .sync_oe     (sync_oe),
  .sync_out    (sync_out),
  .sync_lost   (sync_lost),
  .cfg_err     (cfg_err),
  .period_q    (period_q),
  .boundary    (boundary)
);

// File: tb/test_swclk_sync_sel.sv
`timescale 1ns/1ps
module test_swclk_sync_sel;
  localparam int unsigned SYS_HZ = 200_000_000;
  localparam int unsigned SU     = 300;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       run_en;
  logic [2:0] rate_sel;
  logic [2:0] cfg_code;
  logic       sync_in;
  logic       sync_out, sync_oe, frame_clk, frame_start;
  logic       cfg_valid, slave_mode, cfg_err, sync_lost;
  logic [5:0] gain_db;

  int total = 0;
  int bad   = 0;
  int sync_period = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  swclk_sync_sel #(.SYS_CLK_HZ(SYS_HZ), .STARTUP_CYCLES(SU)) i_swclk_sync_sel (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .rate_sel(rate_sel),
    .cfg_code(cfg_code), .sync_in(sync_in), .sync_out(sync_out),
    .sync_oe(sync_oe), .frame_clk(frame_clk), .frame_start(frame_start),
    .cfg_valid(cfg_valid), .slave_mode(slave_mode), .gain_db(gain_db),
    .cfg_err(cfg_err), .sync_lost(sync_lost)
  );

  // Expected values from the requirement tables.
  function automatic int exp_period(input int code);
    int khz;
    if (code == 0) khz = 400;
    else if (code == 1) khz = 500;
    else if (code == 2) khz = 600;
    else if (code == 3) khz = 1000;
    else khz = 1200;
    return (SYS_HZ / 1000) / khz;
  endfunction

  function automatic int exp_gain(input int step);
    return (step == 0) ? 20 : (step == 1) ? 26 : (step == 2) ? 32 : 36;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Sync clock generator, changes just after the rising clock edge.
  initial begin
    int ph = 0;
    sync_in = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      if (sync_period == 0) begin
        sync_in = 1'b0;
        ph = 0;
      end else begin
        sync_in = (ph < sync_period / 2);
        ph++;
        if (ph >= sync_period) ph = 0;
      end
    end
  end

  initial begin
    repeat (190_000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_up();
  end

  // Advance to the next frame_start; returns the number of cycles waited.
  task automatic next_start(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!frame_start && n < 5000);
  endtask

  // Must be called at a negedge where frame_start is high.
  task automatic measure_frame(output int per, output int hi, output int mism,
                               input int change_at, input logic [2:0] new_sel);
    per  = 0;
    hi   = frame_clk ? 1 : 0;
    mism = (sync_oe && sync_out != frame_clk) ? 1 : 0;
    forever begin
      if (per == change_at) rate_sel = new_sel;
      @(negedge clk);
      per++;
      if (frame_start || per >= 5000) break;
      if (frame_clk) hi++;
      if (sync_oe && sync_out != frame_clk) mism++;
    end
  endtask

  initial begin
    int n, per, hi, mism;
    void'($urandom(32'd2718));
    rst_n = 1'b0; run_en = 1'b0; rate_sel = 3'd0; cfg_code = 3'd2;
    repeat (4) @(negedge clk);
    chk("R4", "reset cfg_valid", cfg_valid, 0);
    chk("R4", "reset frame_clk", frame_clk, 0);
    chk("R4", "reset sync_oe", sync_oe, 0);
    chk("R9", "reset sync_lost", sync_lost, 0);
    chk("R2", "reset cfg_err", cfg_err, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: interrupted start-up restarts the count
    run_en = 1'b1;
    repeat (150) @(negedge clk);
    chk("R4", "valid mid start-up", cfg_valid, 0);
    chk("R4", "sync_oe mid start-up", sync_oe, 0);
    run_en = 1'b0;
    repeat (5) @(negedge clk);
    run_en = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!cfg_valid && n < 2000);
    chk("R4", "start-up length after restart", n, SU);

    // R5: master decode
    chk("R5", "master slave_mode", slave_mode, 0);
    chk("R5", "master gain", gain_db, exp_gain(2));

    // R6: frozen configuration
    cfg_code = 3'd7;
    run_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4", "frame_clk with run_en low", frame_clk, 0);
    run_en = 1'b1;
    repeat (400) @(negedge clk);
    chk("R6", "gain after cfg change", gain_db, exp_gain(2));
    chk("R6", "role after cfg change", slave_mode, 0);
    chk("R6", "cfg_valid held", cfg_valid, 1);

    // R1/R7: each rate code
    for (int c = 0; c < 5; c++) begin
      rate_sel = 3'(c);
      next_start(n);
      measure_frame(per, hi, mism, -1, 3'd0);
      chk("R1", $sformatf("period code %0d", c), per, exp_period(c));
      chk("R1", $sformatf("high time code %0d", c), hi, exp_period(c) / 2);
      chk("R7", "sync_out mismatch", mism, 0);
      chk("R7", "sync_oe master", sync_oe, 1);
      chk("R9", "sync_lost master", sync_lost, 0);
    end

    // R3: change mid-frame
    rate_sel = 3'd3;
    next_start(n);
    measure_frame(per, hi, mism, -1, 3'd0);
    measure_frame(per, hi, mism, 50, 3'd0);
    chk("R3", "frame in progress keeps old period", per, exp_period(3));
    measure_frame(per, hi, mism, -1, 3'd0);
    chk("R3", "next frame uses new period", per, exp_period(0));

    // R2: reserved code
    rate_sel = 3'd2;
    next_start(n);
    measure_frame(per, hi, mism, -1, 3'd0);
    rate_sel = 3'd6;
    @(negedge clk);
    chk("R2", "cfg_err raised", cfg_err, 1);
    next_start(n);
    measure_frame(per, hi, mism, -1, 3'd0);
    chk("R2", "period held on reserved code", per, exp_period(2));
    rate_sel = 3'd1;
    @(negedge clk);
    chk("R2", "cfg_err cleared", cfg_err, 0);

    // R1: seeded random rate sequence
    for (int i = 0; i < 10; i++) begin
      int code = int'($urandom % 5);
      rate_sel = 3'(code);
      next_start(n);
      measure_frame(per, hi, mism, -1, 3'd0);
      chk("R1", $sformatf("random period code %0d", code), per, exp_period(code));
    end

    // Slave role after a new reset
    rst_n = 1'b0; run_en = 1'b0; cfg_code = 3'd5; rate_sel = 3'd0;
    sync_period = 350;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run_en = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!cfg_valid && n < 2000);
    chk("R4", "start-up length slave", n, SU);
    chk("R5", "slave role", slave_mode, 1);
    chk("R5", "slave gain", gain_db, exp_gain(1));
    next_start(n);
    for (int k = 0; k < 2; k++) begin
      measure_frame(per, hi, mism, -1, 3'd0);
      chk("R8", "slave frame interval", per, 350);
      chk("R8", "slave high time", hi, 175);
      chk("R8", "slave sync_oe", sync_oe, 0);
    end

    // R8: edge latency
    begin
      logic prev;
      prev = sync_in;
      n = 0;
      forever begin
        @(negedge clk);
        n++;
        if ((sync_in && !prev) || n > 2000) break;
        prev = sync_in;
      end
      @(negedge clk);
      chk("R8", "no start after one edge", frame_start, 0);
      @(negedge clk);
      chk("R8", "start after two edges", frame_start, 1);
      chk("R8", "frame_clk follows sync", frame_clk, 1);
    end

    // R9: sync lost
    chk("R9", "sync_lost while running", sync_lost, 0);
    next_start(n);
    sync_period = 0;
    repeat (4 * 500 - 20) @(negedge clk);
    chk("R9", "sync_lost before limit", sync_lost, 0);
    repeat (40) @(negedge clk);
    chk("R9", "sync_lost after limit", sync_lost, 1);
    sync_period = 350;
    next_start(n);
    repeat (3) @(negedge clk);
    chk("R9", "sync_lost cleared", sync_lost, 0);

    finish_up();
  end

endmodule